// File: doc/BRIEF.md
# Indirect Parameter RAM Access Register

This block puts a 128-word by 16-bit parameter store behind one 32-bit host register. The host writes a single command word that names a RAM address in its top seven bits. It also carries a store flag, the data to store and a set of persistent control bits. A fixed-length access sequencer then performs the RAM operation and reports progress through a busy bit that the host polls. When a load completes, the addressed word appears in the low half of the same register.

The control bits are three channel freeze flags and one global converter disable. They are sampled from every accepted command word and then held, so RAM accesses never disturb them. The converter logic outside this block reads them continuously. A command word that arrives while an access is still in flight is dropped completely.

Top module: `srp_host_port`

## Requirements
- R1: After reset the register reads as all zeros, busy is low, and every RAM word reads back as 0.
- R2: Bits 31:25 of an accepted command word select the RAM word (0 to 127) and read back unchanged until the next accepted command.
- R3: When bit 24 of an accepted command is 1, bits 15:0 are stored at the selected address, and bits 15:0 of the register show the stored value once busy clears.
- R4: Bits 18:16 always read as 0, whatever the host wrote into them.
- R5: When bit 24 of an accepted command is 0, the command is a load: the RAM is not modified, and once busy clears bits 15:0 of the register hold the selected word.
- R6: Busy (bit 23) rises in the cycle after a command is accepted and stays high for exactly 4 cycles.
- R7: Bit 22 (global disable) and bits 21, 20, 19 (freeze of the synth, DAC and ADC channels) take their values from each accepted command and hold them through the access and afterwards.
- R8: A command written while busy is high has no effect: no RAM change, no change to the address, data, store flag or control bits.
- R9: Every address from 0 to 127 stores its own word independently of all the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle strobe: present a command word |
| host_wdata | input | 32 | Command word |
| host_rdata | output | 32 | Current register contents |
| ch_freeze | output | 3 | Held freeze flags (bit 2 synth, bit 1 DAC, bit 0 ADC) |
| conv_disable | output | 1 | Held global disable |

## Verification
If the sequencer counter holds a wrong value, the busy bit shows it at once: the pulse is longer or shorter than four cycles, and the host sees that by counting polls. A latched address or store flag that is corrupted leads to a wrong RAM word or an untouched one. That shows only on a later load from the affected address, so the bench reads back every location it wrote. A wrong capture of the control bits appears on the held outputs and in bits 22:19 in the very next cycle after the command.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 16;
    localparam int NUM_FRZ    = 3;
    localparam int ADDR_LSB   = 25;
    localparam int STORE_BIT  = 24;
    localparam int BUSY_BIT   = 23;
    localparam int DIS_BIT    = 22;
    localparam int FRZ_LSB    = 19;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic               store;
        logic               dis;
        logic [NUM_FRZ-1:0] frz;
        logic [DATA_W-1:0]  data;
    } host_cmd_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    function automatic host_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        host_cmd_t c;
        c.addr  = w[ADDR_LSB +: ADDR_W];
        c.store = w[STORE_BIT];
        c.dis   = w[DIS_BIT];
        c.frz   = w[FRZ_LSB +: NUM_FRZ];
        c.data  = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_view(input host_cmd_t c,
                                                    input logic busy);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ADDR_LSB +: ADDR_W]  = c.addr;
        w[STORE_BIT]           = c.store;
        w[BUSY_BIT]            = busy;
        w[DIS_BIT]             = c.dis;
        w[FRZ_LSB +: NUM_FRZ]  = c.frz;
        w[DATA_W-1:0]          = c.data;
        return w;
    endfunction

endpackage

// File: rtl/srp_param_ram.sv
module srp_param_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (wr_en && (addr == ADDR_W'(i))) begin
                cells[i] <= wr_word;
            end
        end
    end

    assign rd_word = cells[addr];

endmodule

// File: rtl/srp_access_seq.sv
module srp_access_seq #(
    parameter int ACC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    import srp_pkg::*;

    localparam int CNT_W = (ACC_CYCLES > 2) ? $clog2(ACC_CYCLES) : 1;
    localparam int RUN_W = $clog2(ACC_CYCLES + 1) + 1;

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy = (state_q == SEQ_RUN);
    assign done = busy && (cnt_q == CNT_W'(ACC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (done) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // independent run-length counter for the busy window checks
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_BUSY_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < RUN_W'(ACC_CYCLES)));   // R6
    AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == RUN_W'(ACC_CYCLES)));   // R6
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);   // R6

endmodule

// File: rtl/srp_ctrl_bits.sv
module srp_ctrl_bits (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  srp_pkg::host_cmd_t           cmd_in,
    input  logic                         busy,
    input  logic                         done,
    input  logic [srp_pkg::DATA_W-1:0]   ram_word,
    output srp_pkg::host_cmd_t           held
);
    import srp_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (accept) begin
            held.addr  <= cmd_in.addr;
            held.store <= cmd_in.store;
            held.dis   <= cmd_in.dis;
            held.frz   <= cmd_in.frz;
            if (cmd_in.store) begin
                held.data <= cmd_in.data;
            end
        end else if (done && !held.store) begin
            held.data <= ram_word;
        end
    end

    AST_CTRL_HELD_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(held.dis) && $stable(held.frz)));   // R7
    AST_ADDR_HELD_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(held.addr) && $stable(held.store)));   // R8
    AST_STORE_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && held.store) |=> $stable(held.data));   // R3

endmodule

// File: rtl/srp_host_port.sv
module srp_host_port #(
    parameter int ACC_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic [2:0]  ch_freeze,
    output logic        conv_disable
);
    import srp_pkg::*;

    host_cmd_t         cmd_in;
    host_cmd_t         held;
    logic              busy;
    logic              done;
    logic              accept;
    logic              ram_we;
    logic [DATA_W-1:0] ram_word;

    assign cmd_in = decode_cmd(host_wdata);
    assign accept = host_wr && !busy;
    assign ram_we = done && held.store;

    srp_access_seq #(.ACC_CYCLES(ACC_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy),
        .done  (done)
    );

    srp_ctrl_bits u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .cmd_in   (cmd_in),
        .busy     (busy),
        .done     (done),
        .ram_word (ram_word),
        .held     (held)
    );

    srp_param_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ram_we),
        .addr    (held.addr),
        .wr_word (held.data),
        .rd_word (ram_word)
    );

    assign host_rdata   = pack_view(held, busy);
    assign ch_freeze    = held.frz;
    assign conv_disable = held.dis;

    always_comb begin
        AST_RSV_ZERO: assert (host_rdata[18:16] == 3'b000);   // R4
    end

    AST_RAM_WR_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (busy && host_rdata[STORE_BIT]));   // R3
    AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (host_wr && busy) |=> ($stable(ch_freeze) && $stable(conv_disable)));   // R8
    AST_CTRL_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !busy) |=> (ch_freeze == $past(host_wdata[21:19])));   // R7

endmodule

// File: tb/srp_host_port_tb.sv
module srp_host_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [2:0]  ch_freeze;
    logic        conv_disable;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] model [128];

    always #2 clk = ~clk;

    srp_host_port dut_i (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .ch_freeze    (ch_freeze),
        .conv_disable (conv_disable)
    );

    function automatic logic [31:0] cmd(input int a, input bit st, input bit dis,
                                        input logic [2:0] frz, input logic [15:0] d);
        return {a[6:0], st, 1'b0, dis, frz, 3'b000, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] w, output int blen);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
        blen = 0;
        while (host_rdata[23]) begin
            blen++;
            @(negedge clk);
        end
    endtask

    task automatic load(input int a, output logic [15:0] v);
        int bl;
        access(cmd(a, 1'b0, 1'b0, 3'b000, 16'h0000), bl);
        v = host_rdata[15:0];
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 register", host_rdata, 32'h0);
        check("R1 freeze", {29'd0, ch_freeze}, 32'h0);
        load(77, v);
        check("R1 ram word 77", {16'd0, v}, 32'h0);
        load(0, v);
        check("R1 ram word 0", {16'd0, v}, 32'h0);
    endtask

    task automatic t_store_load;
        int bl;
        logic [15:0] v;
        access(cmd(5, 1'b1, 1'b0, 3'b010, 16'hA5A5), bl);
        model[5] = 16'hA5A5;
        check("R6 busy length store", bl, 4);
        check("R3 R2 R7 view after store", host_rdata, cmd(5, 1'b1, 1'b0, 3'b010, 16'hA5A5));
        access(cmd(5, 1'b0, 1'b0, 3'b010, 16'h1234), bl);
        check("R6 busy length load", bl, 4);
        check("R5 view after load", host_rdata, cmd(5, 1'b0, 1'b0, 3'b010, 16'hA5A5));
        load(5, v);
        check("R5 load does not modify", {16'd0, v}, {16'd0, model[5]});
    endtask

    task automatic t_reserved;
        int bl;
        access(cmd(9, 1'b1, 1'b0, 3'b000, 16'h0F0F) | 32'h0007_0000, bl);
        model[9] = 16'h0F0F;
        check("R4 reserved zero", {29'd0, host_rdata[18:16]}, 32'h0);
        check("R3 store beside reserved", {16'd0, host_rdata[15:0]}, 32'h0000_0F0F);
    endtask

    task automatic t_ctrl_hold;
        int bl;
        logic [15:0] v;
        access(cmd(12, 1'b1, 1'b1, 3'b101, 16'h7777), bl);
        model[12] = 16'h7777;
        check("R7 freeze held", {29'd0, ch_freeze}, 32'd5);
        check("R7 disable held", {31'd0, conv_disable}, 32'd1);
        repeat (6) @(negedge clk);
        check("R7 still held", {28'd0, host_rdata[22:19]}, 32'hD);
        access(cmd(12, 1'b0, 1'b0, 3'b000, 16'h0), bl);
        check("R7 cleared", {28'd0, conv_disable, ch_freeze}, 32'h0);
        v = host_rdata[15:0];
        check("R5 load word 12", {16'd0, v}, 32'h7777);
    endtask

    task automatic t_drop_busy;
        logic [15:0] v;
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = cmd(20, 1'b1, 1'b0, 3'b001, 16'hBEEF);
        @(negedge clk);
        host_wdata = cmd(21, 1'b1, 1'b1, 3'b111, 16'hDEAD);
        @(negedge clk);
        host_wr = 1'b0;
        while (host_rdata[23]) @(negedge clk);
        model[20] = 16'hBEEF;
        check("R8 view keeps first command", host_rdata, cmd(20, 1'b1, 1'b0, 3'b001, 16'hBEEF));
        check("R8 control untouched", {28'd0, conv_disable, ch_freeze}, 32'h1);
        load(21, v);
        check("R8 dropped store", {16'd0, v}, 32'h0);
    endtask

    task automatic t_edges;
        logic [15:0] v;
        int bl;
        access(cmd(0, 1'b1, 1'b0, 3'b000, 16'h1111), bl);
        access(cmd(127, 1'b1, 1'b0, 3'b000, 16'hFFFE), bl);
        model[0] = 16'h1111;
        model[127] = 16'hFFFE;
        check("R2 top address view", {25'd0, host_rdata[31:25]}, 32'd127);
        load(0, v);
        check("R9 word 0", {16'd0, v}, 32'h1111);
        load(127, v);
        check("R9 word 127", {16'd0, v}, 32'hFFFE);
    endtask

    task automatic t_sweep;
        int bl;
        logic [15:0] v;
        int bad = 0;
        for (int a = 0; a < 128; a++) begin
            logic [15:0] p = 16'(a * 16'h0203) ^ 16'h5A00;
            access(cmd(a, 1'b1, 1'b0, 3'b000, p), bl);
            model[a] = p;
        end
        for (int a = 0; a < 128; a++) begin
            load(a, v);
            if (v !== model[a]) begin
                bad++;
                check("R9 sweep word", {16'd0, v}, {16'd0, model[a]});
            end
        end
        check("R9 sweep mismatches", bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_store_load();
        t_reserved();
        t_ctrl_hold();
        t_drop_busy();
        t_edges();
        t_sweep();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule